// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two parallel buses, called A and B, in each of several independent sections. Each section either forwards the live value of one bus onto the other or drives the other bus from a value it captured earlier. Every section holds two storage registers: one takes its value from bus A, the other from bus B. Each register has its own capture strobe. A per-direction source select picks live or stored data for the bus being driven. An active-low enable and a direction control decide which bus the section drives, if any.

Tri-state pins appear as separate input, output and output-enable vectors for each bus. The capture strobes are sampled on the system clock. A register loads on the clock edge where its strobe is first seen high after being low. Loading does not depend on the enable, direction or select controls. The reset input is asynchronous and active low. Its release is synchronised to the clock inside the block.

Top module: `reg_bus_xcvr`

## Requirements
- R1: While reset is held and after it is released, both storage registers of every section hold zero until a capture occurs, so a section driving from a register drives 0x00.
- R2: When a section's enable is high, both of its output-enable vectors are all zeros and both of its output vectors read zero, whatever the other controls are.
- R3: With the enable low, a direction value of 1 sets the B output-enable vector to all ones and the A one to all zeros. A direction value of 0 does the reverse. The two buses of a section are never both enabled.
- R4: While B is driven, a low A-to-B select puts the live A input on the B output in the same cycle.
- R5: While B is driven, a high A-to-B select puts the A-side register on the B output.
- R6: While A is driven, the B-to-A select chooses the live B input when low and the B-side register when high.
- R7: The A-side register loads the A input on the first clock edge where its strobe is sampled high after being sampled low. If the strobe stays high, or stays low, the register keeps its value.
- R8: The B-side register follows the same rule with its own strobe and the B input.
- R9: A capture takes effect whatever the enable and direction controls are: with the section disabled and while the section is driving.
- R10: When a register is captured while it feeds the driven bus, the new value is on that bus from the cycle after the capture edge.
- R11: Sections are independent. A capture or control change in one section leaves every other section's outputs unchanged.
- R12: A strobe that is already high when reset is released does not cause a capture. The strobe must go low and then high again before the register loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| out_en_n | input | SECTIONS | Active-low output enable per section |
| drive_b | input | SECTIONS | Direction per section: 1 drives B, 0 drives A |
| a2b_stored | input | SECTIONS | A-to-B source: 1 stored, 0 live |
| b2a_stored | input | SECTIONS | B-to-A source: 1 stored, 0 live |
| cap_a | input | SECTIONS | Capture strobe for the A-side register |
| cap_b | input | SECTIONS | Capture strobe for the B-side register |
| a_in | input | SECTIONS*WIDTH | Value seen on bus A |
| a_out | output | SECTIONS*WIDTH | Value driven onto bus A |
| a_oe | output | SECTIONS*WIDTH | Per-bit drive enable for bus A |
| b_in | input | SECTIONS*WIDTH | Value seen on bus B |
| b_out | output | SECTIONS*WIDTH | Value driven onto bus B |
| b_oe | output | SECTIONS*WIDTH | Per-bit drive enable for bus B |

## Verification
A bad register value is visible only through a stored-source path. The bench therefore selects stored data on the driven bus immediately after every capture and reads the register one cycle after the edge that loaded it. An edge detector stuck high or stuck low shows up the same way. It either reloads while a strobe is held high or misses a fresh rise, and the driven bus then differs from the expected value within two cycles. Wrong routing or enable decoding is combinational. It shows up on the outputs in the same cycle as the control change, and the bench checks every combination of enable, direction and source select.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // number of flops in the reset release synchroniser
  localparam int unsigned RST_SYNC_STAGES = 2;

  // per-section control word as seen by the routing logic
  typedef struct packed {
    logic oe_n;        // active-low output enable
    logic to_b;        // 1: drive bus B, 0: drive bus A
    logic a2b_stored;  // B takes stored A data when set
    logic b2a_stored;  // A takes stored B data when set
  } lane_ctrl_t;

  // source selection for one direction
  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } path_src_e;

endpackage

// File: rtl/xcvr_rst_sync.sv
module xcvr_rst_sync #(
  parameter int unsigned STAGES = xcvr_pkg::RST_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/xcvr_capture_reg.sv
module xcvr_capture_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic             seen_q;   // strobe level at the previous edge
  logic             seen_d;
  logic             load;
  logic [WIDTH-1:0] data_q;
  logic [WIDTH-1:0] data_d;

  always_comb begin
    load   = strobe & ~seen_q;
    seen_d = strobe;
    data_d = load ? d : data_q;
  end

  // seen_q resets high so a strobe held across reset is not taken as a rise
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b1;
      data_q <= '0;
    end else begin
      seen_q <= seen_d;
      if (load) begin
        data_q <= data_d;
      end
    end
  end

  assign q = data_q;

endmodule

// File: rtl/xcvr_route.sv
module xcvr_route
  import xcvr_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  lane_ctrl_t       ctrl,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic [WIDTH-1:0] a_held,
  input  logic [WIDTH-1:0] b_held,
  output logic [WIDTH-1:0] a_out,
  output logic [WIDTH-1:0] a_oe,
  output logic [WIDTH-1:0] b_out,
  output logic [WIDTH-1:0] b_oe
);

  path_src_e        src_ab;
  path_src_e        src_ba;
  logic [WIDTH-1:0] toward_b;
  logic [WIDTH-1:0] toward_a;

  always_comb begin
    src_ab   = ctrl.a2b_stored ? SRC_STORED : SRC_LIVE;
    src_ba   = ctrl.b2a_stored ? SRC_STORED : SRC_LIVE;
    toward_b = (src_ab == SRC_STORED) ? a_held : a_in;
    toward_a = (src_ba == SRC_STORED) ? b_held : b_in;
  end

  always_comb begin
    a_oe  = '0;
    b_oe  = '0;
    a_out = '0;
    b_out = '0;
    if (!ctrl.oe_n) begin
      if (ctrl.to_b) begin
        b_oe  = '1;
        b_out = toward_b;
      end else begin
        a_oe  = '1;
        a_out = toward_a;
      end
    end
  end

endmodule

// File: rtl/xcvr_section.sv
module xcvr_section
  import xcvr_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  lane_ctrl_t       ctrl,
  input  logic             cap_a,
  input  logic             cap_b,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] a_out,
  output logic [WIDTH-1:0] a_oe,
  output logic [WIDTH-1:0] b_out,
  output logic [WIDTH-1:0] b_oe
);

  logic [WIDTH-1:0] a_held;
  logic [WIDTH-1:0] b_held;

  // capture paths run from the strobes alone, never from ctrl
  xcvr_capture_reg #(.WIDTH(WIDTH)) u_hold_a (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (cap_a),
    .d      (a_in),
    .q      (a_held)
  );

  xcvr_capture_reg #(.WIDTH(WIDTH)) u_hold_b (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (cap_b),
    .d      (b_in),
    .q      (b_held)
  );

  xcvr_route #(.WIDTH(WIDTH)) u_route (
    .ctrl   (ctrl),
    .a_in   (a_in),
    .b_in   (b_in),
    .a_held (a_held),
    .b_held (b_held),
    .a_out  (a_out),
    .a_oe   (a_oe),
    .b_out  (b_out),
    .b_oe   (b_oe)
  );

endmodule

// File: rtl/reg_bus_xcvr.sv
module reg_bus_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned WIDTH    = 8,
  parameter int unsigned SECTIONS = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [SECTIONS-1:0]       out_en_n,
  input  logic [SECTIONS-1:0]       drive_b,
  input  logic [SECTIONS-1:0]       a2b_stored,
  input  logic [SECTIONS-1:0]       b2a_stored,
  input  logic [SECTIONS-1:0]       cap_a,
  input  logic [SECTIONS-1:0]       cap_b,
  input  logic [SECTIONS*WIDTH-1:0] a_in,
  output logic [SECTIONS*WIDTH-1:0] a_out,
  output logic [SECTIONS*WIDTH-1:0] a_oe,
  input  logic [SECTIONS*WIDTH-1:0] b_in,
  output logic [SECTIONS*WIDTH-1:0] b_out,
  output logic [SECTIONS*WIDTH-1:0] b_oe
);

  localparam int unsigned BUS_W = SECTIONS * WIDTH;

  logic rst_sync_n;

  xcvr_rst_sync #(.STAGES(RST_SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar s = 0; s < SECTIONS; s++) begin : g_sect
    localparam int unsigned LO = s * WIDTH;
    lane_ctrl_t ctrl;

    always_comb begin
      ctrl.oe_n       = out_en_n[s];
      ctrl.to_b       = drive_b[s];
      ctrl.a2b_stored = a2b_stored[s];
      ctrl.b2a_stored = b2a_stored[s];
    end

    xcvr_section #(.WIDTH(WIDTH)) u_sect (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .ctrl  (ctrl),
      .cap_a (cap_a[s]),
      .cap_b (cap_b[s]),
      .a_in  (a_in[LO +: WIDTH]),
      .b_in  (b_in[LO +: WIDTH]),
      .a_out (a_out[LO +: WIDTH]),
      .a_oe  (a_oe[LO +: WIDTH]),
      .b_out (b_out[LO +: WIDTH]),
      .b_oe  (b_oe[LO +: WIDTH])
    );
  end

  if (BUS_W == 0) begin : g_bad_size
    initial $error("reg_bus_xcvr: WIDTH and SECTIONS must be non-zero");
  end

endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
  parameter int unsigned WIDTH    = 8,
  parameter int unsigned SECTIONS = 2
) (
  input logic                      clk,
  input logic                      rst_sync_n,
  input logic [SECTIONS-1:0]       out_en_n,
  input logic [SECTIONS-1:0]       drive_b,
  input logic [SECTIONS-1:0]       a2b_stored,
  input logic [SECTIONS-1:0]       b2a_stored,
  input logic [SECTIONS-1:0]       cap_a,
  input logic [SECTIONS-1:0]       cap_b,
  input logic [SECTIONS*WIDTH-1:0] a_in,
  input logic [SECTIONS*WIDTH-1:0] a_out,
  input logic [SECTIONS*WIDTH-1:0] a_oe,
  input logic [SECTIONS*WIDTH-1:0] b_in,
  input logic [SECTIONS*WIDTH-1:0] b_out,
  input logic [SECTIONS*WIDTH-1:0] b_oe
);

  // armed: at least one edge has passed since the synchronised release
  logic armed;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) armed <= 1'b0;
    else             armed <= 1'b1;
  end

  for (genvar s = 0; s < SECTIONS; s++) begin : g_chk
    logic [WIDTH-1:0] ai, ao, ae, bi, bo, be;
    logic stored_on_b, stored_on_a;
    assign ai = a_in[s*WIDTH +: WIDTH];
    assign ao = a_out[s*WIDTH +: WIDTH];
    assign ae = a_oe[s*WIDTH +: WIDTH];
    assign bi = b_in[s*WIDTH +: WIDTH];
    assign bo = b_out[s*WIDTH +: WIDTH];
    assign be = b_oe[s*WIDTH +: WIDTH];
    assign stored_on_b = !out_en_n[s] && drive_b[s] && a2b_stored[s];
    assign stored_on_a = !out_en_n[s] && !drive_b[s] && b2a_stored[s];

    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
      out_en_n[s] |-> (ae == '0 && be == '0 && ao == '0 && bo == '0));

    p_one_side_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
      !((|ae) && (|be)));

    p_uniform_oe_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (ae == '0 || ae == '1) && (be == '0 || be == '1));

    p_live_ab_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (!out_en_n[s] && drive_b[s] && !a2b_stored[s]) |-> (bo == ai));

    p_live_ba_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (!out_en_n[s] && !drive_b[s] && !b2a_stored[s]) |-> (ao == bi));

    p_hold_a_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (armed && !cap_a[s] && stored_on_b) ##1 stored_on_b |-> $stable(bo));

    p_hold_b_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (armed && !cap_b[s] && stored_on_a) ##1 stored_on_a |-> $stable(ao));

    p_load_a_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (armed && $rose(cap_a[s]) && stored_on_b) ##1 stored_on_b |-> (bo == $past(ai)));

    p_load_b_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (armed && $rose(cap_b[s]) && stored_on_a) ##1 stored_on_a |-> (ao == $past(bi)));
  end

endmodule

bind reg_bus_xcvr xcvr_checker #(.WIDTH(WIDTH), .SECTIONS(SECTIONS)) u_xcvr_checker (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .out_en_n   (out_en_n),
  .drive_b    (drive_b),
  .a2b_stored (a2b_stored),
  .b2a_stored (b2a_stored),
  .cap_a      (cap_a),
  .cap_b      (cap_b),
  .a_in       (a_in),
  .a_out      (a_out),
  .a_oe       (a_oe),
  .b_in       (b_in),
  .b_out      (b_out),
  .b_oe       (b_oe)
);

// File: tb/reg_bus_xcvr_bench.sv
module reg_bus_xcvr_bench;

  localparam int W = 8;
  localparam int S = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic [S-1:0]   out_en_n, drive_b, a2b_stored, b2a_stored, cap_a, cap_b;
  logic [S*W-1:0] a_in, b_in;
  wire  [S*W-1:0] a_out, a_oe, b_out, b_oe;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  reg_bus_xcvr #(.WIDTH(W), .SECTIONS(S)) u_reg_bus_xcvr (
    .clk(clk), .rst_n(rst_n), .out_en_n(out_en_n), .drive_b(drive_b),
    .a2b_stored(a2b_stored), .b2a_stored(b2a_stored), .cap_a(cap_a), .cap_b(cap_b),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe), .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  // stimulus and expectation for section 0; stored A = 3C, stored B = A5
  typedef struct packed {
    logic       oe_n;
    logic       to_b;
    logic       sab;
    logic       sba;
    logic [7:0] a;
    logic [7:0] b;
    logic       x_aoe;
    logic       x_boe;
    logic [7:0] x_aout;
    logic [7:0] x_bout;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,1'b0,1'b0,8'h11,8'h22,1'b0,1'b0,8'h00,8'h00},
    '{1'b1,1'b1,1'b1,1'b1,8'h11,8'h22,1'b0,1'b0,8'h00,8'h00},
    '{1'b0,1'b1,1'b0,1'b0,8'h5A,8'hC3,1'b0,1'b1,8'h00,8'h5A},
    '{1'b0,1'b1,1'b1,1'b0,8'h5A,8'hC3,1'b0,1'b1,8'h00,8'h3C},
    '{1'b0,1'b1,1'b0,1'b1,8'hF0,8'h0F,1'b0,1'b1,8'h00,8'hF0},
    '{1'b0,1'b1,1'b1,1'b1,8'hF0,8'h0F,1'b0,1'b1,8'h00,8'h3C},
    '{1'b0,1'b0,1'b0,1'b0,8'h5A,8'hC3,1'b1,1'b0,8'hC3,8'h00},
    '{1'b0,1'b0,1'b0,1'b1,8'h5A,8'hC3,1'b1,1'b0,8'hA5,8'h00},
    '{1'b0,1'b0,1'b1,1'b0,8'hFF,8'h81,1'b1,1'b0,8'h81,8'h00},
    '{1'b0,1'b0,1'b1,1'b1,8'hFF,8'h81,1'b1,1'b0,8'hA5,8'h00}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse_a(input int l);
    @(negedge clk); cap_a[l] = 1'b1;
    @(negedge clk); cap_a[l] = 1'b0;
    #1;
  endtask

  task automatic pulse_b(input int l);
    @(negedge clk); cap_b[l] = 1'b1;
    @(negedge clk); cap_b[l] = 1'b0;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    out_en_n = '1; drive_b = '0; a2b_stored = '0; b2a_stored = '0;
    cap_a = 2'b01;  // held high across reset release (R12)
    cap_b = '0;
    a_in = 16'h0077; b_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;

    // R2: both sections idle
    check("R2 idle a_oe", a_oe, 16'h0000);
    check("R2 idle b_oe", b_oe, 16'h0000);

    // R1 / R12: stored values are zero, held-high strobe did not load 77
    out_en_n[0] = 1'b0; drive_b[0] = 1'b1; a2b_stored[0] = 1'b1; #1;
    check("R1 R12 stored A after reset", b_out[7:0], 8'h00);
    drive_b[0] = 1'b0; b2a_stored[0] = 1'b1; #1;
    check("R1 stored B after reset", a_out[7:0], 8'h00);

    // R12: low then high strobe now loads
    @(negedge clk); cap_a[0] = 1'b0;
    pulse_a(0);
    drive_b[0] = 1'b1; #1;
    check("R12 R7 fresh rise loads", b_out[7:0], 8'h77);

    // R9: captures while section disabled
    out_en_n[0] = 1'b1;
    a_in[7:0] = 8'h3C; pulse_a(0);
    b_in[7:0] = 8'hA5; pulse_b(0);
    check("R2 disabled outputs", {a_out[7:0], b_out[7:0]}, 16'h0000);

    // routing table over every enable/direction/select combination
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      out_en_n[0] = VECS[i].oe_n; drive_b[0] = VECS[i].to_b;
      a2b_stored[0] = VECS[i].sab; b2a_stored[0] = VECS[i].sba;
      a_in[7:0] = VECS[i].a; b_in[7:0] = VECS[i].b;
      #1;
      check("R3 a_oe", a_oe[7:0], {8{VECS[i].x_aoe}});
      check("R3 b_oe", b_oe[7:0], {8{VECS[i].x_boe}});
      check(VECS[i].oe_n ? "R2 a_out" : "R6 a_out", a_out[7:0], VECS[i].x_aout);
      check(VECS[i].oe_n ? "R2 b_out" : (VECS[i].sab ? "R5 b_out" : "R4 b_out"),
            b_out[7:0], VECS[i].x_bout);
      check("R11 other section idle", {a_oe[15:8], b_oe[15:8]}, 16'h0000);
    end

    // R10 / R9: capture while stored A feeds driven B
    @(negedge clk);
    out_en_n[0] = 1'b0; drive_b[0] = 1'b1; a2b_stored[0] = 1'b1; a_in[7:0] = 8'h96;
    #1;
    check("R5 before capture", b_out[7:0], 8'h3C);
    pulse_a(0);
    check("R10 R9 capture while driving B", b_out[7:0], 8'h96);

    // R7: strobe held high loads once only
    @(negedge clk); cap_a[0] = 1'b1; a_in[7:0] = 8'h11;
    @(negedge clk); a_in[7:0] = 8'h22;
    @(negedge clk); a_in[7:0] = 8'h33;
    @(negedge clk); #1;
    check("R7 held strobe no reload", b_out[7:0], 8'h11);
    cap_a[0] = 1'b0; a_in[7:0] = 8'h44;
    repeat (2) @(negedge clk); #1;
    check("R7 low strobe holds", b_out[7:0], 8'h11);

    // R8 / R10: B side
    drive_b[0] = 1'b0; b2a_stored[0] = 1'b1; b_in[7:0] = 8'hC7;
    pulse_b(0);
    check("R10 capture while driving A", a_out[7:0], 8'hC7);
    b_in[7:0] = 8'h5E;
    repeat (2) @(negedge clk); #1;
    check("R8 no strobe holds", a_out[7:0], 8'hC7);

    // R11: section 1 capture leaves section 0 alone
    a_in[15:8] = 8'hE7; a_in[7:0] = 8'h00;
    pulse_a(1);
    drive_b[0] = 1'b1; #1;
    check("R11 section 0 stored A kept", b_out[7:0], 8'h11);
    out_en_n[1] = 1'b0; drive_b[1] = 1'b1; a2b_stored[1] = 1'b1; #1;
    check("R11 section 1 stored A", b_out[15:8], 8'hE7);
    check("R11 section 0 unaffected", b_out[7:0], 8'h11);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule